// File: doc/BRIEF.md
# Layer wake and shutdown controller

This block lives inside a bus interface node. It tracks the serial bits of each incoming message, checks the destination address against the node's own address, and powers up the attached layer logic only for messages meant for this node. Power-up begins only once a third data bit has arrived, so zero-length messages leave the layer asleep. The layer's power, clock, isolation and reset controls then change one per harvested bus edge.

An interjection can arrive at any point. While the layer is still isolated, an interjection simply gates it off again. Once isolation is gone, the sequence runs to completion and a sticky transaction-failed flag is raised. A shutdown message takes effect only after a valid end-of-message. The next edge acknowledges it by isolating the layer, stopping its clock and raising a sleep request. The edge after that removes layer power. The sleep request stays high until the next message starts.

States: `SQ_OFF` (layer gated), `SQ_PWR` (power on), `SQ_CLK` (clock on), `SQ_ISO` (isolation released), `SQ_RUN` (reset released), `SQ_PEND` (shutdown confirmed, waiting for an edge), `SQ_ACK` (isolated, sleep requested), `SQ_DOWN` (gated, sleep requested).

Transitions:
- `SQ_OFF`→`SQ_PWR` on a wake.
- `SQ_PWR`→`SQ_CLK`→`SQ_ISO`→`SQ_RUN` on successive edges.
- `SQ_PWR`/`SQ_CLK`→`SQ_OFF` on an interjection.
- `SQ_RUN`→`SQ_PEND` on end-of-message with the shutdown command.
- `SQ_PEND`→`SQ_ACK`→`SQ_DOWN` on edges.
- `SQ_DOWN`→`SQ_OFF` on message start.

Top module: `layer_pwr_ctrl`

## Requirements
- R1: After reset, layer_pwr=0, layer_clk_en=0, layer_iso=1, layer_rst=1, txn_fail=0 and sleep_req=0.
- R2: The first bit strobed after msg_start is the most significant address bit. Bits are taken MSB first, and the layer wakes only when all ADDR_W address bits equal node_addr.
- R3: With a matching address, layer_pwr rises in the cycle after the third data bit (bit index ADDR_W+2) is strobed. A message that ends after zero, one or two data bits never powers the layer.
- R4: After layer_pwr rises, each edge_stb pulse takes one step, in this order: layer_clk_en goes to 1, then layer_iso goes to 0, then layer_rst goes to 0.
- R5: An interject pulse while power is on and layer_iso is still 1 returns all layer controls to the gated state in the next cycle, and txn_fail stays 0.
- R6: An interject pulse after layer_iso has gone to 0 but before layer_rst has gone to 0 sets txn_fail. The next edge_stb still releases layer_rst.
- R7: txn_fail stays 1 until a fail_clr pulse clears it. A set and a clear in the same cycle leave it at 1.
- R8: A shutdown takes effect only from the running state, through an eom_ok pulse while shut_cmd=1. The next edge_stb then drives sleep_req=1, layer_iso=1, layer_rst=1 and layer_clk_en=0, with layer_pwr still 1.
- R9: The edge_stb after the acknowledgement drives layer_pwr to 0. sleep_req stays 1 until the next msg_start.
- R10: A second matching wake message while the layer runs leaves all controls unchanged.
- R11: In the running state, shut_cmd without eom_ok, or eom_ok with shut_cmd=0, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| msg_start | input | 1 | Pulse: new message, the next bit is the address MSB |
| bit_stb | input | 1 | Pulse: one received bit is latched |
| bit_val | input | 1 | Value of the latched bit |
| edge_stb | input | 1 | Pulse: harvested bus control edge |
| interject | input | 1 | Pulse: interjection seen on the bus |
| eom_ok | input | 1 | Pulse: valid end-of-message from the transmitter |
| shut_cmd | input | 1 | Level: the current message is a shutdown command |
| fail_clr | input | 1 | Pulse: layer clears the failure flag |
| node_addr | input | ADDR_W | This node's address |
| layer_pwr | output | 1 | Layer power enable |
| layer_clk_en | output | 1 | Layer clock enable |
| layer_iso | output | 1 | Layer isolation, 1 = isolated |
| layer_rst | output | 1 | Layer reset, 1 = held in reset |
| txn_fail | output | 1 | Sticky transaction-failed flag |
| sleep_req | output | 1 | Shutdown request to the sleep controller |

## Verification
The assertions assume that every strobe input is a single-cycle pulse. They also assume that msg_start never coincides with a bit strobe, and that a wake can only follow a fresh msg_start. Under these assumptions, any rise of power, clock or reset release can be traced to the preceding pulse. The stimulus drives every strobe for exactly one cycle from tasks, with idle cycles in between. The only deliberate overlap is interject together with fail_clr, which exercises the set-over-clear priority.

// File: rtl/lwc_pkg.sv
package lwc_pkg;

    typedef enum logic [2:0] {
        SQ_OFF,
        SQ_PWR,
        SQ_CLK,
        SQ_ISO,
        SQ_RUN,
        SQ_PEND,
        SQ_ACK,
        SQ_DOWN
    } sq_state_t;

    typedef struct packed {
        logic pwr;
        logic clk_en;
        logic iso;
        logic rst;
        logic sleep;
    } pctl_t;

endpackage

// File: rtl/lwc_rx_track.sv
module lwc_rx_track #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_start,
    input  logic              msg_end,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic [ADDR_W-1:0] node_addr,
    output logic              wake_go
);
    localparam int SH_W  = ADDR_W - 1;
    localparam int CNT_W = $clog2(ADDR_W + 4);
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] ADDR_BITS = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] WAKE_IDX  = CNT_W'(ADDR_W + 2);
    localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(ADDR_W + 3);

    logic             active;
    logic [CNT_W-1:0] cnt;
    logic [SH_W-1:0]  shreg;
    logic             hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            shreg  <= '0;
            hit    <= 1'b0;
        end else if (msg_start) begin
            active <= 1'b1;
            cnt    <= '0;
            shreg  <= '0;
            hit    <= 1'b0;
        end else if (active && msg_end) begin
            active <= 1'b0;
        end else if (active && bit_stb) begin
            if (cnt < ADDR_BITS) begin
                shreg <= SH_W'({shreg, bit_val});
            end
            if (cnt == LAST_ADDR) begin
                hit <= ({shreg, bit_val} == node_addr);
            end
            if (cnt != CNT_SAT) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // third data bit of a message addressed to this node
    assign wake_go = active && bit_stb && !msg_start && !msg_end
                     && (cnt == WAKE_IDX) && hit;

endmodule

// File: rtl/lwc_seq.sv
module lwc_seq
    import lwc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wake_go,
    input  logic      edge_stb,
    input  logic      interject,
    input  logic      eom_ok,
    input  logic      shut_cmd,
    input  logic      msg_start,
    output sq_state_t state
);
    sq_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SQ_OFF;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SQ_OFF:  if (wake_go) nxt = SQ_PWR;
            SQ_PWR:  if (interject) nxt = SQ_OFF;
                     else if (edge_stb) nxt = SQ_CLK;
            SQ_CLK:  if (interject) nxt = SQ_OFF;
                     else if (edge_stb) nxt = SQ_ISO;
            SQ_ISO:  if (edge_stb) nxt = SQ_RUN;
            SQ_RUN:  if (eom_ok && shut_cmd) nxt = SQ_PEND;
            SQ_PEND: if (edge_stb) nxt = SQ_ACK;
            SQ_ACK:  if (edge_stb) nxt = SQ_DOWN;
            SQ_DOWN: if (msg_start) nxt = SQ_OFF;
            default: nxt = SQ_OFF;
        endcase
    end

endmodule

// File: rtl/lwc_out_dec.sv
module lwc_out_dec
    import lwc_pkg::*;
(
    input  sq_state_t state,
    output pctl_t     ctl
);
    always_comb begin
        unique case (state)
            SQ_OFF:  ctl = '{pwr: 1'b0, clk_en: 1'b0, iso: 1'b1, rst: 1'b1, sleep: 1'b0};
            SQ_PWR:  ctl = '{pwr: 1'b1, clk_en: 1'b0, iso: 1'b1, rst: 1'b1, sleep: 1'b0};
            SQ_CLK:  ctl = '{pwr: 1'b1, clk_en: 1'b1, iso: 1'b1, rst: 1'b1, sleep: 1'b0};
            SQ_ISO:  ctl = '{pwr: 1'b1, clk_en: 1'b1, iso: 1'b0, rst: 1'b1, sleep: 1'b0};
            SQ_RUN,
            SQ_PEND: ctl = '{pwr: 1'b1, clk_en: 1'b1, iso: 1'b0, rst: 1'b0, sleep: 1'b0};
            SQ_ACK:  ctl = '{pwr: 1'b1, clk_en: 1'b0, iso: 1'b1, rst: 1'b1, sleep: 1'b1};
            SQ_DOWN: ctl = '{pwr: 1'b0, clk_en: 1'b0, iso: 1'b1, rst: 1'b1, sleep: 1'b1};
            default: ctl = '{pwr: 1'b0, clk_en: 1'b0, iso: 1'b1, rst: 1'b1, sleep: 1'b0};
        endcase
    end

endmodule

// File: rtl/lwc_fail_flag.sv
module lwc_fail_flag
    import lwc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sq_state_t state,
    input  logic      interject,
    input  logic      fail_clr,
    output logic      fail
);
    logic set_fail;

    // interjection once isolation is already released
    assign set_fail = interject && (state == SQ_ISO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail <= 1'b0;
        end else if (set_fail) begin
            fail <= 1'b1;
        end else if (fail_clr) begin
            fail <= 1'b0;
        end
    end

endmodule

// File: rtl/layer_pwr_ctrl.sv
module layer_pwr_ctrl
    import lwc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_start,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              edge_stb,
    input  logic              interject,
    input  logic              eom_ok,
    input  logic              shut_cmd,
    input  logic              fail_clr,
    input  logic [ADDR_W-1:0] node_addr,
    output logic              layer_pwr,
    output logic              layer_clk_en,
    output logic              layer_iso,
    output logic              layer_rst,
    output logic              txn_fail,
    output logic              sleep_req
);
    logic      wake_go;
    logic      msg_end;
    sq_state_t state;
    pctl_t     ctl;

    assign msg_end = interject | eom_ok;

    lwc_rx_track #(.ADDR_W(ADDR_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_start (msg_start),
        .msg_end   (msg_end),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .node_addr (node_addr),
        .wake_go   (wake_go)
    );

    lwc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_go   (wake_go),
        .edge_stb  (edge_stb),
        .interject (interject),
        .eom_ok    (eom_ok),
        .shut_cmd  (shut_cmd),
        .msg_start (msg_start),
        .state     (state)
    );

    lwc_out_dec u_dec (
        .state (state),
        .ctl   (ctl)
    );

    lwc_fail_flag u_fail (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .interject (interject),
        .fail_clr  (fail_clr),
        .fail      (txn_fail)
    );

    assign layer_pwr    = ctl.pwr;
    assign layer_clk_en = ctl.clk_en;
    assign layer_iso    = ctl.iso;
    assign layer_rst    = ctl.rst;
    assign sleep_req    = ctl.sleep;

endmodule

// File: rtl/layer_pwr_ctrl_chk.sv
module layer_pwr_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_stb,
    input logic interject,
    input logic fail_clr,
    input logic layer_pwr,
    input logic layer_clk_en,
    input logic layer_iso,
    input logic layer_rst,
    input logic txn_fail,
    input logic sleep_req
);
    a_r3_wake_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(layer_pwr) |-> $past(bit_stb));

    a_r4_clk_after_pwr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(layer_clk_en) |-> $past(layer_pwr) && layer_iso && layer_rst);

    a_r4_iso_after_clk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(layer_iso) |-> $past(layer_clk_en) && layer_rst);

    a_r4_rst_after_iso: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(layer_rst) |-> $past(!layer_iso));

    a_r5_regate_on_interject: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(layer_pwr) && !$past(sleep_req)) |-> $past(interject));

    a_r6_fail_from_interject: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txn_fail) |-> $past(interject));

    a_r7_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_fail && !fail_clr) |=> txn_fail);

    a_r8_ack_isolates: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> layer_iso && layer_rst && !layer_clk_en);

    a_r9_ack_before_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_req) |-> layer_pwr);

endmodule

bind layer_pwr_ctrl layer_pwr_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_stb      (bit_stb),
    .interject    (interject),
    .fail_clr     (fail_clr),
    .layer_pwr    (layer_pwr),
    .layer_clk_en (layer_clk_en),
    .layer_iso    (layer_iso),
    .layer_rst    (layer_rst),
    .txn_fail     (txn_fail),
    .sleep_req    (sleep_req)
);

// File: tb/layer_pwr_ctrl_test.sv
module layer_pwr_ctrl_test;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] MY_ADDR = 8'hB1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic msg_start = 0, bit_stb = 0, bit_val = 0, edge_stb = 0;
    logic interject = 0, eom_ok = 0, shut_cmd = 0, fail_clr = 0;
    logic [ADDR_W-1:0] node_addr = MY_ADDR;
    logic layer_pwr, layer_clk_en, layer_iso, layer_rst, txn_fail, sleep_req;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    layer_pwr_ctrl #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .bit_stb(bit_stb),
        .bit_val(bit_val), .edge_stb(edge_stb), .interject(interject),
        .eom_ok(eom_ok), .shut_cmd(shut_cmd), .fail_clr(fail_clr),
        .node_addr(node_addr), .layer_pwr(layer_pwr), .layer_clk_en(layer_clk_en),
        .layer_iso(layer_iso), .layer_rst(layer_rst), .txn_fail(txn_fail),
        .sleep_req(sleep_req)
    );

    // behavioural reference: phase 0 gated, 1 powered, 2 clocked, 3 unisolated,
    // 4 running, 5 shutdown confirmed, 6 acknowledged, 7 asleep
    int ph = 0;
    bit rx_on = 0;
    int nb = 0;
    int acc = 0;
    bit m_hit = 0;
    bit m_fail = 0;

    always @(posedge clk) begin
        bit w;
        w = 0;
        if (!rst_n) begin
            ph = 0; rx_on = 0; nb = 0; acc = 0; m_hit = 0; m_fail = 0;
        end else begin
            if (msg_start) begin
                rx_on = 1; nb = 0; acc = 0; m_hit = 0;
            end else if (rx_on && (interject || eom_ok)) begin
                rx_on = 0;
            end else if (rx_on && bit_stb) begin
                nb = nb + 1;
                if (nb <= ADDR_W) acc = acc * 2 + int'(bit_val);
                if (nb == ADDR_W) m_hit = (acc == int'(node_addr));
                if (nb == ADDR_W + 3 && m_hit) w = 1;
            end
            if (interject && ph == 3) m_fail = 1;
            else if (fail_clr) m_fail = 0;
            case (ph)
                0: if (w) ph = 1;
                1, 2: if (interject) ph = 0; else if (edge_stb) ph = ph + 1;
                3: if (edge_stb) ph = 4;
                4: if (eom_ok && shut_cmd) ph = 5;
                5, 6: if (edge_stb) ph = ph + 1;
                7: if (msg_start) ph = 0;
                default: ph = 0;
            endcase
        end
    end

    function automatic logic [4:0] exp_ctl(int p);
        // {pwr, clk_en, iso, rst, sleep}
        case (p)
            1: return 5'b10110;
            2: return 5'b11110;
            3: return 5'b11010;
            4, 5: return 5'b11000;
            6: return 5'b10111;
            7: return 5'b00111;
            default: return 5'b00110;
        endcase
    endfunction

    // per-cycle comparison against the reference (R4 sequence, R7 flag)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [5:0] got, exp;
            got = {layer_pwr, layer_clk_en, layer_iso, layer_rst, sleep_req, txn_fail};
            exp = {exp_ctl(ph), m_fail};
            total++;
            if (got !== exp) begin
                bad++;
                $display("FAIL R4 per-cycle model compare at %0t got=%b expected=%b",
                         $time, got, exp);
            end
        end
    end

    task automatic chk(string tag, logic got, logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_start();
        msg_start = 1; step(); msg_start = 0;
    endtask

    task automatic t_bit(logic b);
        bit_stb = 1; bit_val = b; step(); bit_stb = 0; bit_val = 0;
    endtask

    task automatic t_edge();
        edge_stb = 1; step(); edge_stb = 0;
    endtask

    task automatic t_int();
        interject = 1; step(); interject = 0;
    endtask

    task automatic t_eom();
        eom_ok = 1; step(); eom_ok = 0;
    endtask

    task automatic send_msg(logic [ADDR_W-1:0] a, int ndata);
        t_start();
        for (int i = ADDR_W - 1; i >= 0; i--) t_bit(a[i]);
        for (int j = 0; j < ndata; j++) t_bit(j[0]);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        chk("R1 reset pwr", layer_pwr, 1'b0);
        chk("R1 reset clk_en", layer_clk_en, 1'b0);
        chk("R1 reset iso", layer_iso, 1'b1);
        chk("R1 reset rst", layer_rst, 1'b1);
        chk("R1 reset fail", txn_fail, 1'b0);
        chk("R1 reset sleep", sleep_req, 1'b0);

        // R2: bit-reversed own address and an unrelated address
        send_msg(8'h8D, 5); t_eom(); step();
        chk("R2 reversed address no wake", layer_pwr, 1'b0);
        send_msg(8'h00, 4); t_eom(); step();
        chk("R2 foreign address no wake", layer_pwr, 1'b0);

        // R3: zero-, one- and two-bit bodies
        for (int n = 0; n < 3; n++) begin
            send_msg(MY_ADDR, n); t_int(); step();
            chk("R3 short message no wake", layer_pwr, 1'b0);
        end

        // R5: interject in the powered and the clocked phase
        send_msg(MY_ADDR, 3);
        chk("R3 wake after third data bit", layer_pwr, 1'b1);
        t_int();
        chk("R5 interject regates pwr", layer_pwr, 1'b0);
        chk("R5 interject no fail", txn_fail, 1'b0);
        send_msg(MY_ADDR, 3); t_edge();
        chk("R4 clock on first edge", layer_clk_en, 1'b1);
        t_int();
        chk("R5 regate from clocked", layer_clk_en | layer_pwr, 1'b0);
        chk("R5 iso asserted after regate", layer_iso, 1'b1);

        // R3/R4 full wake
        send_msg(MY_ADDR, 2);
        chk("R3 two data bits no wake yet", layer_pwr, 1'b0);
        t_bit(1'b1);
        chk("R3 pwr after third bit", layer_pwr, 1'b1);
        chk("R4 clock still off", layer_clk_en, 1'b0);
        t_edge();
        chk("R4 clock step", layer_clk_en, 1'b1);
        chk("R4 iso still on", layer_iso, 1'b1);
        t_edge();
        chk("R4 iso step", layer_iso, 1'b0);
        chk("R4 rst still on", layer_rst, 1'b1);
        t_edge();
        chk("R4 rst step", layer_rst, 1'b0);

        // R10: second wake while running
        send_msg(MY_ADDR, 4); t_edge(); t_edge(); t_edge();
        chk("R10 still running rst", layer_rst, 1'b0);
        chk("R10 still running iso", layer_iso, 1'b0);
        t_eom();

        // R11: shutdown command without confirmation, and confirmation without command
        shut_cmd = 1; t_edge(); t_edge(); t_int(); t_edge();
        chk("R11 no eom no shutdown", sleep_req, 1'b0);
        chk("R11 still running", layer_rst, 1'b0);
        shut_cmd = 0; t_eom(); t_edge(); t_edge();
        chk("R11 eom without command", sleep_req, 1'b0);
        chk("R11 power kept", layer_pwr, 1'b1);

        // R8/R9 confirmed shutdown
        shut_cmd = 1; t_eom(); shut_cmd = 0;
        chk("R8 nothing before edge", sleep_req, 1'b0);
        t_edge();
        chk("R8 sleep request", sleep_req, 1'b1);
        chk("R8 layer isolated", layer_iso, 1'b1);
        chk("R8 layer reset", layer_rst, 1'b1);
        chk("R8 clock stopped", layer_clk_en, 1'b0);
        chk("R8 power held", layer_pwr, 1'b1);
        t_edge();
        chk("R9 power removed", layer_pwr, 1'b0);
        chk("R9 sleep held", sleep_req, 1'b1);
        step(); t_edge();
        chk("R9 sleep still held", sleep_req, 1'b1);

        // R6/R7: interject after isolation release, together with a clear
        send_msg(MY_ADDR, 3);
        chk("R9 sleep dropped on message", sleep_req, 1'b0);
        t_edge(); t_edge();
        interject = 1; fail_clr = 1; step(); interject = 0; fail_clr = 0;
        chk("R7 set wins over clear", txn_fail, 1'b1);
        chk("R6 iso stays released", layer_iso, 1'b0);
        t_edge();
        chk("R6 sequence completes", layer_rst, 1'b0);
        chk("R6 fail raised", txn_fail, 1'b1);
        repeat (4) step();
        chk("R7 fail held", txn_fail, 1'b1);
        fail_clr = 1; step(); fail_clr = 0;
        chk("R7 fail cleared", txn_fail, 1'b0);
        step();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL R1 watchdog got=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule